// File: doc/BRIEF.md
# Nibble-Wide Double-Edge Link Port

A point-to-point port that carries whole words between two devices over a 4-bit data bus, a link clock and an acknowledge line. The port is set to transmit or to receive. When it transmits, it takes words from a two-entry output buffer and sends each word as a series of nibbles, least significant nibble first, with one nibble on every edge of the link clock it generates. When it receives, it captures a nibble on every edge of the incoming link clock, rebuilds the word and places it in a two-entry input buffer. The local logic then reads the word from that buffer.

A configuration bit selects the word size: 32 bits (8 nibbles) or 48 bits (12 nibbles). The receiver's acknowledge output tells the far transmitter whether it may begin another word. The transmitter starts a word only while its acknowledge input is high. Between words it holds the link clock low. The transmitter toggles the link clock once per system clock. The receiver's system clock must run at least twice as fast as the incoming link clock.

Top module: `link_port`

## Requirements
- R1: When synchronous reset `rst` is high, both buffer counts read 0, `lk_ack_o` and `lk_clk_o` are low, and the mode reads receive (`mode_tx`=0) with 32-bit words (`mode_w48`=0).
- R2: In transmit mode with 32-bit words, each word goes out as 8 nibbles on `lk_dat_o`, least significant first. `lk_clk_o` toggles on every system clock within a word, with one nibble on each toggle. Words leave in the order they were loaded.
- R3: In transmit mode with 48-bit words, each word goes out as 12 nibbles in the same way.
- R4: The transmitter starts a word only on a cycle in which `lk_ack_i` is high. While no word can start, `lk_clk_o` stays low and no nibble is sent.
- R5: In receive mode, every change of `lk_clk_i` captures `lk_dat_i` as the next nibble, least significant first. After 8 or 12 nibbles, depending on word size, the word enters the input buffer. `rx_data` shows the oldest buffered word, with bits 47:32 zero in 32-bit mode. `rx_pop` removes that word.
- R6: In receive mode, `lk_ack_o` is high only when the input buffer is empty, or when it holds one word and no partial word is being assembled. It is low whenever two words are held.
- R7: Each buffer holds at most two words, and `tx_cnt` and `rx_cnt` report 0, 1 or 2. `tx_ready` is low while the output buffer holds two words, and `tx_valid` loads a word only when `tx_ready` is high.
- R8: A configuration write (`cfg_we` with `cfg_tx`, `cfg_w48`) takes effect on the next cycle only when both buffers are empty and no word is in flight in either direction. Otherwise it is ignored.
- R9: In transmit mode, `lk_clk_i` and `lk_dat_i` are ignored and `lk_ack_o` is low. In receive mode, `lk_clk_o` stays low and `tx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tx | input | 1 | Direction to apply: 1 = transmit, 0 = receive |
| cfg_w48 | input | 1 | Word size to apply: 1 = 48 bits, 0 = 32 bits |
| mode_tx | output | 1 | Current direction |
| mode_w48 | output | 1 | Current word size |
| tx_valid | input | 1 | Load `tx_data` into the output buffer |
| tx_data | input | 48 | Word to send (low 32 bits in 32-bit mode) |
| tx_ready | output | 1 | Output buffer can accept a word |
| tx_cnt | output | 2 | Words in the output buffer |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_data | output | 48 | Oldest received word |
| rx_cnt | output | 2 | Words in the input buffer |
| lk_clk_o | output | 1 | Link clock driven when transmitting |
| lk_dat_o | output | 4 | Link data driven when transmitting |
| lk_ack_i | input | 1 | Acknowledge from the far receiver |
| lk_clk_i | input | 1 | Link clock from the far transmitter |
| lk_dat_i | input | 4 | Link data from the far transmitter |
| lk_ack_o | output | 1 | Acknowledge to the far transmitter |

## Verification
The bench drives inputs on the falling system clock edge and samples outputs on the next falling edge. A configuration change, a buffer load or a buffer removal is therefore visible one cycle after its strobe. A received nibble is captured on the first rising edge after `lk_clk_i` changes. The word and the updated `rx_cnt` and `lk_ack_o` are visible on the falling edge that follows the last nibble. When transmitting, the first nibble and the rising `lk_clk_o` appear one cycle after the start decision, and the remaining nibbles follow one per cycle. The bench checks the value of `lk_ack_i` that was present at the decision edge, and it checks that consecutive link clock edges within a word are exactly one cycle apart.

// File: rtl/link_port.sv
module link_port #(
  parameter int NW = 4,
  parameter int WS = 32,
  parameter int WL = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_tx,
  input  logic          cfg_w48,
  output logic          mode_tx,
  output logic          mode_w48,
  input  logic          tx_valid,
  input  logic [WL-1:0] tx_data,
  output logic          tx_ready,
  output logic [1:0]    tx_cnt,
  input  logic          rx_pop,
  output logic [WL-1:0] rx_data,
  output logic [1:0]    rx_cnt,
  output logic          lk_clk_o,
  output logic [NW-1:0] lk_dat_o,
  input  logic          lk_ack_i,
  input  logic          lk_clk_i,
  input  logic [NW-1:0] lk_dat_i,
  output logic          lk_ack_o
);
  localparam int CW = $clog2(WL / NW + 1);

  logic [WL-1:0] tb0, tb1, tsh, rb0, rb1, asm_r, asm_n;
  logic [CW-1:0] tnc, anc;
  logic          clk_q;

  wire [CW-1:0] nnib     = mode_w48 ? CW'(WL / NW) : CW'(WS / NW);
  wire          idle     = tx_cnt == 2'd0 && rx_cnt == 2'd0 && tnc == '0 && anc == '0;
  assign        tx_ready = mode_tx && tx_cnt != 2'd2;
  wire          tx_push  = tx_valid && tx_ready;
  wire          tx_start = mode_tx && tnc == '0 && tx_cnt != 2'd0 && lk_ack_i;
  wire          rx_edge  = !mode_tx && (lk_clk_i != clk_q);
  wire          rx_done  = rx_edge && anc == nnib - 1'b1;
  wire          rx_push  = rx_done && rx_cnt != 2'd2;
  wire          rx_take  = rx_pop && rx_cnt != 2'd0;

  assign rx_data  = rb0;
  assign lk_ack_o = !rst && !mode_tx && (rx_cnt == 2'd0 || (rx_cnt == 2'd1 && anc == '0));

  always_comb asm_n = ((anc == '0) ? '0 : asm_r) | (WL'(lk_dat_i) << (NW * anc));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_tx  <= 1'b0;
      mode_w48 <= 1'b0;
    end else if (cfg_we && idle) begin
      mode_tx  <= cfg_tx;
      mode_w48 <= cfg_w48;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tx_cnt <= 2'd0;
    else case ({tx_push, tx_start})
      2'b10: begin
        if (tx_cnt == 2'd0) tb0 <= tx_data;
        else tb1 <= tx_data;
        tx_cnt <= tx_cnt + 2'd1;
      end
      2'b01: begin
        tb0 <= tb1;
        tx_cnt <= tx_cnt - 2'd1;
      end
      2'b11: begin
        if (tx_cnt == 2'd1) tb0 <= tx_data;
        else begin
          tb0 <= tb1;
          tb1 <= tx_data;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tnc      <= '0;
      lk_clk_o <= 1'b0;
      lk_dat_o <= '0;
    end else if (tx_start) begin
      lk_dat_o <= tb0[NW-1:0];
      tsh      <= tb0 >> NW;
      tnc      <= nnib - 1'b1;
      lk_clk_o <= 1'b1;
    end else if (tnc != '0) begin
      lk_dat_o <= tsh[NW-1:0];
      tsh      <= tsh >> NW;
      tnc      <= tnc - 1'b1;
      lk_clk_o <= ~lk_clk_o;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= 1'b0;
      anc   <= '0;
    end else begin
      clk_q <= lk_clk_i;
      if (rx_edge) begin
        anc   <= rx_done ? '0 : anc + 1'b1;
        asm_r <= asm_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rx_cnt <= 2'd0;
    else case ({rx_push, rx_take})
      2'b10: begin
        if (rx_cnt == 2'd0) rb0 <= asm_n;
        else rb1 <= asm_n;
        rx_cnt <= rx_cnt + 2'd1;
      end
      2'b01: begin
        rb0 <= rb1;
        rx_cnt <= rx_cnt - 2'd1;
      end
      2'b11: begin
        if (rx_cnt == 2'd1) rb0 <= asm_n;
        else begin
          rb0 <= rb1;
          rb1 <= asm_n;
        end
      end
      default: ;
    endcase
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) tx_cnt != 2'd3 && rx_cnt != 2'd3); // R7
  AST_ACK_FULL: assert property (@(posedge clk) disable iff (rst) rx_cnt == 2'd2 |-> !lk_ack_o); // R6
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) rx_done |-> rx_cnt != 2'd2 || rx_take); // R6
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst) !mode_tx |-> !lk_clk_o); // R9
  AST_START_ACK: assert property (@(posedge clk) disable iff (rst) $rose(lk_clk_o) && $past(tnc) == '0 |-> $past(lk_ack_i)); // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst) (tx_cnt != 2'd0 || rx_cnt != 2'd0) |=> $stable(mode_tx) && $stable(mode_w48)); // R8
endmodule

// File: tb/tb_link_port.sv
module tb_link_port;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_tx = 0, cfg_w48 = 0;
  logic mode_tx, mode_w48;
  logic tx_valid = 0;
  logic [47:0] tx_data = '0;
  logic tx_ready;
  logic [1:0] tx_cnt, rx_cnt;
  logic rx_pop = 0;
  logic [47:0] rx_data;
  logic lk_clk_o, lk_ack_i, lk_clk_i = 0, lk_ack_o;
  logic [3:0] lk_dat_o, lk_dat_i = '0;

  link_port dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tx(cfg_tx), .cfg_w48(cfg_w48),
    .mode_tx(mode_tx), .mode_w48(mode_w48), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_cnt(tx_cnt), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_cnt(rx_cnt), .lk_clk_o(lk_clk_o), .lk_dat_o(lk_dat_o), .lk_ack_i(lk_ack_i),
    .lk_clk_i(lk_clk_i), .lk_dat_i(lk_dat_i), .lk_ack_o(lk_ack_o)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  logic [47:0] exp_q[$];
  int nib_i = 0, last_cyc = 0, words_seen = 0;
  logic [47:0] cur = '0;
  logic clk_prev = 1'b0;
  bit ack_rand = 0, ack_fix = 1, mon_w48 = 0;

  always #(CLK_NS / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [47:0] fit_word(input logic [47:0] d, input bit w48);
    return w48 ? d : {16'h0, d[31:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  always @(negedge clk) begin
    if (!rst && lk_clk_o !== clk_prev) begin
      if (nib_i == 0) begin
        chk(lk_ack_i == 1'b1, "R4", 48'(lk_ack_i), 48'd1);
        cur = '0;
      end else chk(cyc - last_cyc == 1, "R2", 48'(cyc - last_cyc), 48'd1);
      cur[nib_i*4 +: 4] = lk_dat_o;
      nib_i++;
      last_cyc = cyc;
      if (nib_i == (mon_w48 ? 12 : 8)) begin
        nib_i = 0;
        words_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R2", cur, 48'h0);
        else begin
          logic [47:0] e;
          e = exp_q.pop_front();
          chk(cur == e, mon_w48 ? "R3" : "R2", cur, e);
        end
      end
    end
    clk_prev = lk_clk_o;
    lk_ack_i = ack_rand ? ($urandom % 4 != 0) : ack_fix;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input bit t, input bit w);
    cfg_we = 1; cfg_tx = t; cfg_w48 = w;
    @(negedge clk);
    cfg_we = 0;
    mon_w48 = mode_w48;
  endtask

  task automatic push_tx(input logic [47:0] d);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_data = d;
    exp_q.push_back(fit_word(d, mon_w48));
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R2", 48'(exp_q.size()), 48'd0);
    tick(2);
  endtask

  task automatic rx_nib(input logic [3:0] n);
    lk_dat_i = n;
    lk_clk_i = ~lk_clk_i;
    repeat (1 + $urandom % 2) @(negedge clk);
  endtask

  task automatic rx_word(input logic [47:0] d, input int nn);
    for (int i = 0; i < nn; i++) rx_nib(d[i*4 +: 4]);
  endtask

  task automatic rx_take(input logic [47:0] e);
    chk(rx_data == e, "R5", rx_data, e);
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [47:0] d1, d2, d3;
    int w;
    void'($urandom(32'h1ee7));
    tick(3);
    chk(tx_cnt == 0 && rx_cnt == 0, "R1", {44'h0, tx_cnt, rx_cnt}, 48'h0);
    chk(lk_ack_o == 0 && lk_clk_o == 0, "R1", {46'h0, lk_ack_o, lk_clk_o}, 48'h0);
    chk(mode_tx == 0 && mode_w48 == 0, "R1", {46'h0, mode_tx, mode_w48}, 48'h0);
    rst = 0;
    tick(1);
    chk(lk_ack_o == 1, "R6", 48'(lk_ack_o), 48'd1);
    chk(tx_ready == 0, "R9", 48'(tx_ready), 48'd0);

    d1 = 48'($urandom); d2 = 48'($urandom); d3 = 48'($urandom);
    rx_word(d1, 8);
    rx_word(d2, 8);
    chk(rx_cnt == 2, "R7", 48'(rx_cnt), 48'd2);
    chk(lk_ack_o == 0, "R6", 48'(lk_ack_o), 48'd0);
    rx_take(d1);
    chk(lk_ack_o == 1, "R6", 48'(lk_ack_o), 48'd1);
    rx_nib(d3[3:0]);
    rx_nib(d3[7:4]);
    chk(lk_ack_o == 0, "R6", 48'(lk_ack_o), 48'd0);
    for (int i = 2; i < 8; i++) rx_nib(d3[i*4 +: 4]);
    chk(rx_cnt == 2, "R7", 48'(rx_cnt), 48'd2);
    rx_take(d2);
    rx_take(d3);
    chk(rx_cnt == 0, "R7", 48'(rx_cnt), 48'd0);

    cfg(0, 1);
    chk(mode_w48 == 1 && mode_tx == 0, "R8", {46'h0, mode_tx, mode_w48}, 48'h1);
    for (int k = 0; k < 4; k++) begin
      d1 = {16'($urandom), 32'($urandom)};
      rx_word(d1, 12);
      rx_take(d1);
    end

    cfg(1, 0);
    chk(mode_tx == 1 && mode_w48 == 0, "R8", {46'h0, mode_tx, mode_w48}, 48'h2);
    chk(lk_ack_o == 0, "R9", 48'(lk_ack_o), 48'd0);
    ack_rand = 1;
    for (int k = 0; k < 6; k++) push_tx({16'($urandom), 32'($urandom)});
    drain();

    ack_rand = 0; ack_fix = 0;
    tick(2);
    w = words_seen;
    push_tx(48'h0000_8765_4321);
    push_tx(48'h0000_0fed_cba9);
    tick(20);
    chk(tx_cnt == 2, "R7", 48'(tx_cnt), 48'd2);
    chk(tx_ready == 0, "R7", 48'(tx_ready), 48'd0);
    chk(lk_clk_o == 0 && nib_i == 0 && words_seen == w, "R4", 48'(words_seen - w), 48'd0);
    cfg(0, 1);
    chk(mode_tx == 1 && mode_w48 == 0, "R8", {46'h0, mode_tx, mode_w48}, 48'h2);
    ack_fix = 1;
    drain();
    chk(words_seen == w + 2, "R2", 48'(words_seen - w), 48'd2);

    for (int i = 0; i < 8; i++) rx_nib(4'(i + 3));
    chk(rx_cnt == 0, "R9", 48'(rx_cnt), 48'd0);

    cfg(1, 1);
    chk(mode_w48 == 1, "R8", 48'(mode_w48), 48'd1);
    ack_rand = 1;
    for (int k = 0; k < 5; k++) push_tx({16'($urandom), 32'($urandom)});
    drain();
    ack_rand = 0; ack_fix = 1;

    cfg(0, 0);
    chk(mode_tx == 0 && mode_w48 == 0, "R8", {46'h0, mode_tx, mode_w48}, 48'h0);
    chk(rx_cnt == 0 && lk_clk_o == 0, "R9", {45'h0, rx_cnt, lk_clk_o}, 48'h0);
    d1 = 48'($urandom);
    rx_word(d1, 8);
    rx_take(d1);
    chk(exp_q.size() == 0, "R2", 48'(exp_q.size()), 48'd0);

    summary();
    $finish;
  end
endmodule